// File: doc/BRIEF.md
# Bus Access Cycle Timer

This block paces every bus access after the arbiter has handed the bus to a master. The arbiter owns the first cycle of an access. From the second cycle on it holds the buffer-enable input high, and this block takes over. It counts a fixed run of main cycles, adds any wait cycles that were requested, and pulses ready in the final cycle. The arbiter uses that ready pulse to start the next access.

An access to I/O space is much longer than a memory access. It can also be held back at its start until an external inter-access delay timer reports that the devices are rested. While an I/O access runs, the block drives an I/O read or I/O write strobe and a busy flag that restarts that timer. It also drives a data strobe for every access.

All pins are plain control signals. There is no data path, so no valid/ready handshake applies. The ready output is the completion pulse of the access. The buffer-enable input is expected to fall in the cycle after ready.

Top module: `bus_cycle_timer`

## Requirements
- R1: A memory access (I/O select low, no waits, hold low) produces ready in the 5th cycle in which buffer enable is high. With the arbiter's cycle, this makes six cycles in all.
- R2: An I/O access (I/O select high in the first cycle) lengthens the access by 12 cycles, so ready comes in the 17th cycle.
- R3: Wait input A adds 1 cycle, wait input B adds 2, and both together add 3. Both inputs are sampled only in the first cycle of the access, and later changes have no effect on its length.
- R4: Every cycle in which hold is high extends the access by one cycle, and ready is never asserted while hold is high.
- R5: Ready is a single-cycle pulse in the last cycle of the access. The data strobe is high in every counted cycle of the access, from the first through the ready cycle.
- R6: When I/O select is high and I/O-ready is low in the first cycle, the access does not start. The data strobe, the busy flag and ready all stay low, and counting begins only once I/O-ready is high.
- R7: The I/O busy flag is high in every counted cycle of an I/O access and never during a memory access.
- R8: During an I/O access, I/O read (write input low) or I/O write (write input high) is high in every counted cycle except the first and the last. Neither strobe is ever high during a memory access.
- R9: After reset, and in the cycle after ready, the block is idle: all outputs stay low while buffer enable is low, and the next access again takes its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_en | input | 1 | Buffer enable from the arbiter, high from the second cycle of an access until ready |
| wr | input | 1 | Access direction, 1 = write |
| io_sel | input | 1 | Access targets I/O space |
| wait_a | input | 1 | Request one extra cycle |
| wait_b | input | 1 | Request two extra cycles |
| hold | input | 1 | Continuous wait, stalls while high |
| io_ready | input | 1 | Inter-access delay for I/O has expired |
| strobe | output | 1 | Data strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_busy | output | 1 | I/O access in progress, restarts the delay timer |
| rdy | output | 1 | Last cycle of the access |

## Verification
The bench flips both wait inputs after the first cycle. A timer that samples the waits again would end that access early or late. It holds I/O-ready low for a few cycles at the start of an I/O access. A design that ignored the hold-off would raise the strobe or the busy flag too soon and finish too early. It also raises hold for several cycles, including an access where hold is high in the cycle that would otherwise carry ready, because a design that let ready through there would cut the stall short. Each access is followed by a check that the block is idle, and back-to-back accesses are timed, so that a counter left uncleared after ready shows up as a short second access.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;
  // Extra cycles requested by the two wait inputs: A=1, B=2, both=3.
  function automatic logic [1:0] wait_cycles(input logic wa, input logic wb);
    return {wb, wa};
  endfunction
endpackage

// File: rtl/bct_len_calc.sv
module bct_len_calc #(
  parameter int MAIN_CYC = 5,
  parameter int IO_WAIT  = 12,
  parameter int CW       = 5
) (
  input  logic          io,
  input  logic          wa,
  input  logic          wb,
  output logic [CW-1:0] len
);
  import bus_cycle_pkg::*;
  always_comb begin
    len = CW'(MAIN_CYC) + CW'(wait_cycles(wa, wb));
    if (io) len = len + CW'(IO_WAIT);
  end
endmodule

// File: rtl/bct_seq.sv
module bct_seq #(
  parameter int MAIN_CYC = 5,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_en,
  input  logic          io_sel,
  input  logic          io_ready,
  input  logic          hold,
  input  logic [CW-1:0] len_live,
  output logic          first,
  output logic          active,
  output logic          io_eff,
  output logic          rdy
);
  logic [CW-1:0] cnt_q, len_q, len_eff;
  logic          io_q, blocked;

  always_comb begin
    first   = (cnt_q == '0);
    len_eff = first ? len_live : len_q;
    io_eff  = first ? io_sel : io_q;
    blocked = buf_en && first && io_sel && !io_ready;
    active  = buf_en && !blocked;
    rdy     = active && !hold && (cnt_q == len_eff - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
      io_q  <= 1'b0;
    end else begin
      if (first && active) begin
        len_q <= len_live;
        io_q  <= io_sel;
      end
      if (!active || rdy) cnt_q <= '0;
      else if (!hold)     cnt_q <= cnt_q + CW'(1);
    end
  end

  p_idle_after_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> (cnt_q == '0));
  p_min_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (cnt_q >= CW'(MAIN_CYC - 1)));
  p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hold) |=> $stable(cnt_q));
  p_block_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && io_sel && !io_ready && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/bct_strobe.sv
module bct_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic first,
  input  logic io_eff,
  input  logic rdy,
  input  logic wr,
  output logic strobe,
  output logic io_rd,
  output logic io_wr,
  output logic io_busy
);
  logic mid;
  always_comb begin
    strobe  = active;
    io_busy = active && io_eff;
    mid     = !first && !rdy;
    io_rd   = io_busy && mid && !wr;
    io_wr   = io_busy && mid && wr;
  end

  p_io_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));
  p_rdy_in_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> strobe);
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
  parameter int MAIN_CYC = 5,
  parameter int IO_WAIT  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic buf_en,
  input  logic wr,
  input  logic io_sel,
  input  logic wait_a,
  input  logic wait_b,
  input  logic hold,
  input  logic io_ready,
  output logic strobe,
  output logic io_rd,
  output logic io_wr,
  output logic io_busy,
  output logic rdy
);
  localparam int CW = $clog2(MAIN_CYC + IO_WAIT + 3 + 1);

  logic [CW-1:0] len_live;
  logic          first, active, io_eff;

  bct_len_calc #(.MAIN_CYC(MAIN_CYC), .IO_WAIT(IO_WAIT), .CW(CW)) u_len (
    .io(io_sel), .wa(wait_a), .wb(wait_b), .len(len_live));

  bct_seq #(.MAIN_CYC(MAIN_CYC), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .io_sel(io_sel),
    .io_ready(io_ready), .hold(hold), .len_live(len_live),
    .first(first), .active(active), .io_eff(io_eff), .rdy(rdy));

  bct_strobe u_strb (
    .clk(clk), .rst_n(rst_n), .active(active), .first(first), .io_eff(io_eff),
    .rdy(rdy), .wr(wr), .strobe(strobe), .io_rd(io_rd), .io_wr(io_wr),
    .io_busy(io_busy));

  p_rdy_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);
  p_no_rdy_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !rdy);
  p_mem_no_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !io_busy) |-> !(io_rd || io_wr));
endmodule

// File: tb/bus_cycle_timer_tb.sv
module bus_cycle_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_en = 0, wr = 0, io_sel = 0, wait_a = 0, wait_b = 0, hold = 0, io_ready = 1;
  logic strobe, io_rd, io_wr, io_busy, rdy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bus_cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .wr(wr), .io_sel(io_sel),
    .wait_a(wait_a), .wait_b(wait_b), .hold(hold), .io_ready(io_ready),
    .strobe(strobe), .io_rd(io_rd), .io_wr(io_wr), .io_busy(io_busy), .rdy(rdy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk({strobe, io_rd, io_wr, io_busy, rdy} == 5'b0, "R9 reset idle",
           {strobe, io_rd, io_wr, io_busy, rdy}, 0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  // One access: blk cycles of I/O hold-off, hc cycles of hold from active cycle 3.
  task automatic t_access(input bit io, input bit w, input bit wa, input bit wb,
                          input int blk, input int hc, input string nm);
    int len, a, n_strb, n_busy, n_rd, n_wr, bad_blk;
    len = 5 + (io ? 12 : 0) + int'(wa) + 2 * int'(wb);
    a = 0; n_strb = 0; n_busy = 0; n_rd = 0; n_wr = 0; bad_blk = 0;
    @(negedge clk);
    buf_en = 0; wr = w; io_sel = io; wait_a = wa; wait_b = wb; hold = 0;
    io_ready = (blk == 0);
    @(negedge clk);
    buf_en = 1;
    for (int b = 0; b < blk; b++) begin
      #1 if (strobe || rdy || io_busy) bad_blk++;
      @(negedge clk);
    end
    io_ready = 1;
    forever begin
      a++;
      hold = (hc > 0) && (a >= 3) && (a < 3 + hc);
      if (a == 2) begin wait_a = ~wa; wait_b = ~wb; end
      #1;
      if (strobe)  n_strb++;
      if (io_busy) n_busy++;
      if (io_rd)   n_rd++;
      if (io_wr)   n_wr++;
      if (rdy || a > 60) break;
      @(negedge clk);
    end
    @(negedge clk);
    buf_en = 0; hold = 0;
    #1;
    $display("access %s: %0d cycles", nm, a);
    chk(a == len + hc, "R1 R2 R3 R4 access length", a, len + hc);
    chk(n_strb == a, "R5 strobe span", n_strb, a);
    chk(bad_blk == 0, "R6 hold-off quiet", bad_blk, 0);
    chk(n_busy == (io ? a : 0), "R7 io busy span", n_busy, io ? a : 0);
    chk(n_rd == ((io && !w) ? a - 2 : 0), "R8 io read span", n_rd, (io && !w) ? a - 2 : 0);
    chk(n_wr == ((io && w) ? a - 2 : 0), "R8 io write span", n_wr, (io && w) ? a - 2 : 0);
    chk({strobe, io_rd, io_wr, io_busy, rdy} == 5'b0, "R9 idle after ready",
        {strobe, io_rd, io_wr, io_busy, rdy}, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_access(0, 0, 0, 0, 0, 0, "R1 memory plain");
    t_access(0, 1, 1, 0, 0, 0, "R3 wait A");
    t_access(0, 0, 0, 1, 0, 0, "R3 wait B");
    t_access(0, 1, 1, 1, 0, 0, "R3 both waits");
    t_access(1, 0, 0, 0, 0, 0, "R2 io read");
    t_access(1, 1, 1, 0, 0, 0, "R2 io write wait A");
    t_access(1, 0, 0, 0, 4, 0, "R6 io hold-off");
    t_access(0, 0, 0, 0, 0, 4, "R4 hold mid access");
    t_access(0, 0, 0, 0, 0, 3, "R4 hold over last cycle");
    t_access(1, 1, 0, 1, 2, 5, "R4 R6 io mixed");
    t_access(0, 0, 0, 0, 0, 0, "R9 back to back");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule